// File: doc/BRIEF.md
# Multiplexed 8-bit Host Register Bus Slave

This block connects a host processor to a small register file inside a programmable device. It uses a narrow bus on which the register index and the data share the same eight pins. A separate phase-select input (`ads`) says which of the two the pins carry. Every access therefore takes two bus cycles. First comes an index cycle with `ads` high, which loads a 4-bit register index. Then comes a data cycle with `ads` low, which reads or writes the register that index names. The index stays loaded, so a run of data cycles can target the same register without a fresh index cycle.

The 16-entry register space is split three ways:

- **Inside the block:** interrupt control, a secondary bus-control register, two stream clock dividers and a read-only revision code.
- **Downstream:** the card-access and filter registers are passed to downstream logic through one-cycle read and write strobes. A downstream read stalls the host through the active-low ready output until the data arrives.
- **Unmapped:** the remaining indexes.

An active-low interrupt output reports card-detect changes on the enabled slots. It stays asserted until the host reads the interrupt-control register.

All host inputs are assumed synchronous to `clk`. The block samples them once per clock and acts on the first sampled cycle of each strobe.

Top module: `hbus_mux8_slave`

## Requirements
- R1: A write strobe with `ads`=1 and `cs_n`=0 loads `bus_in[3:0]` as the register index, ignoring `bus_in[7:4]`. The index holds through any number of data cycles until the next index cycle.
- R2: Data writes to the following indexes update the configuration outputs:
  - Index 0x1 stores bits 7:2. `ts_en[1:0]` shows bits 5:4. `tuner_rel[0]` shows bit 3 and `tuner_rel[1]` shows bit 2.
  - Index 0xC sets `div_a`.
  - Index 0xD sets `div_b`.
- R3: A data write to a downstream index (0x4 to 0xA) raises `dn_wr_en` for exactly one cycle per strobe, however long the strobe is held. During that cycle `dn_idx` carries the index and `dn_wdata` carries the data.
- R4: A data read of an in-block index drives `bus_oe`. `rdy_n` is high for one cycle after the strobe is sampled. When `rdy_n` returns low, `bus_out` holds the register value.
- R5: A data read of a downstream index pulses `dn_rd_en` once. `rdy_n` then stays high until the cycle after `dn_rd_valid`, when `bus_out` holds `dn_rd_data` and `rdy_n` is low.
- R6: A read of an unmapped index (0x2, 0x3, 0xB, 0xE) returns 0x00. A write to one changes no output and raises no strobe.
- R7: Index 0xF reads the `REVISION` parameter. Writes to it have no effect.
- R8: Interrupt control (index 0x0):
  - Bit 2 enables interrupts on `card_det[0]` changes. Bit 6 enables interrupts on `card_det[1]` changes. Writing 0x44 enables both.
  - An enabled change drives `irq_n` low two cycles later, and it stays low until a data read of index 0x0.
  - That read returns the stored enables in bits 7:1 and the pending flag in bit 0, and it clears the flag.
- R9: While `cs_n` is high, strobes are ignored: no index change, no register change, no downstream strobe.
- R10: After reset, `rdy_n`=0, `irq_n`=1, `bus_oe`=0 and all configuration outputs are 0.
- R11: Bits 1:0 of index 0x1 read back the `card_det` levels. Writes to those bits are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Active-low chip select |
| ads | input | 1 | Phase select: 1 index cycle, 0 data cycle |
| wr_n | input | 1 | Active-low write strobe |
| rd_n | input | 1 | Active-low read strobe |
| bus_in | input | 8 | Index/data from host |
| bus_out | output | 8 | Read data to host |
| bus_oe | output | 1 | Read data drive enable |
| rdy_n | output | 1 | Active-low ready |
| irq_n | output | 1 | Active-low interrupt |
| card_det | input | 2 | Card-detect levels of the two slots |
| dn_idx | output | 4 | Register index to downstream logic |
| dn_wdata | output | 8 | Write data to downstream logic |
| dn_wr_en | output | 1 | Downstream write strobe |
| dn_rd_en | output | 1 | Downstream read strobe |
| dn_rd_valid | input | 1 | Downstream read data valid |
| dn_rd_data | input | 8 | Downstream read data |
| ts_en | output | 2 | Transport-stream output enables |
| tuner_rel | output | 2 | Tuner reset releases, active high |
| div_a | output | 8 | Stream clock divider A |
| div_b | output | 8 | Stream clock divider B |

## Verification
A corrupted index register shows up on the first later data cycle. The write lands on the wrong configuration output, `dn_idx` names the wrong register, or a read returns another register's value. Each of these is visible within two clocks of the strobe. A stuck wait flag shows as `rdy_n` staying high past the cycle after `dn_rd_valid`, or dropping before the data arrives. A lost or stuck interrupt flag shows as `irq_n` staying high two cycles after an enabled card change, or staying low after the acknowledging read.

// File: rtl/hbm_pkg.sv
package hbm_pkg;
    localparam int DATA_W = 8;
    localparam int IDX_W  = 4;
    localparam int CD_N   = 2;

    localparam logic [IDX_W-1:0] IDX_IRQ   = 4'h0;
    localparam logic [IDX_W-1:0] IDX_BUS2  = 4'h1;
    localparam logic [IDX_W-1:0] IDX_DIV_A = 4'hC;
    localparam logic [IDX_W-1:0] IDX_DIV_B = 4'hD;
    localparam logic [IDX_W-1:0] IDX_REV   = 4'hF;

    // interrupt enable bit of slot k sits at IRQ_EN_BASE + IRQ_EN_STEP*k
    localparam int IRQ_EN_BASE = 2;
    localparam int IRQ_EN_STEP = 4;

    typedef enum logic [1:0] {
        RK_LOCAL = 2'd0,
        RK_DOWN  = 2'd1,
        RK_NONE  = 2'd2
    } reg_kind_e;

    typedef struct packed {
        logic              wr_go;    // first sampled cycle of a write strobe
        logic              rd_go;    // first sampled cycle of a read strobe
        logic              rd_hold;  // read strobe currently held
        logic              ads;      // sampled phase select
        logic [DATA_W-1:0] data;     // sampled bus value
    } host_evt_t;

    function automatic reg_kind_e classify(input logic [IDX_W-1:0] i);
        reg_kind_e k;
        case (i)
            IDX_IRQ, IDX_BUS2, IDX_DIV_A, IDX_DIV_B, IDX_REV: k = RK_LOCAL;
            4'h4, 4'h5, 4'h6, 4'h7, 4'h8, 4'h9, 4'hA:         k = RK_DOWN;
            default:                                          k = RK_NONE;
        endcase
        return k;
    endfunction
endpackage

// File: rtl/hbm_capture.sv
module hbm_capture
    import hbm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_n,
    input  logic              ads,
    input  logic              wr_n,
    input  logic              rd_n,
    input  logic [DATA_W-1:0] bus_in,
    output host_evt_t         evt
);
    logic              s_wr, s_wr_d, s_rd, s_rd_d, s_ads;
    logic [DATA_W-1:0] s_data;

    always_ff @(posedge clk) begin
        if (rst) begin
            s_wr   <= 1'b0;
            s_wr_d <= 1'b0;
            s_rd   <= 1'b0;
            s_rd_d <= 1'b0;
            s_ads  <= 1'b0;
            s_data <= '0;
        end else begin
            s_wr   <= ~cs_n & ~wr_n;
            s_rd   <= ~cs_n & ~rd_n;
            s_wr_d <= s_wr;
            s_rd_d <= s_rd;
            s_ads  <= ads;
            s_data <= bus_in;
        end
    end

    always_comb begin
        evt.wr_go   = s_wr & ~s_wr_d;
        evt.rd_go   = s_rd & ~s_rd_d;
        evt.rd_hold = s_rd;
        evt.ads     = s_ads;
        evt.data    = s_data;
    end
endmodule

// File: rtl/hbm_index.sv
module hbm_index #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] din,
    output logic [W-1:0] idx
);
    always_ff @(posedge clk) begin
        if (rst)       idx <= '0;
        else if (load) idx <= din;
    end
endmodule

// File: rtl/hbm_local_regs.sv
module hbm_local_regs
    import hbm_pkg::*;
#(
    parameter logic [DATA_W-1:0] REVISION = 8'h21
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              ack,
    input  logic [IDX_W-1:0]  idx,
    input  logic [DATA_W-1:0] wdata,
    input  logic [CD_N-1:0]   card_det,
    output logic [DATA_W-1:0] rd_val,
    output logic [1:0]        ts_en,
    output logic [1:0]        tuner_rel,
    output logic [DATA_W-1:0] div_a,
    output logic [DATA_W-1:0] div_b,
    output logic              irq_n
);
    logic [7:1]        ctrl_q;
    logic [7:2]        bus2_q;
    logic [CD_N-1:0]   cd_q, cd_q2, hit;
    logic              pend;

    for (genvar k = 0; k < CD_N; k++) begin : g_slot
        assign hit[k] = (cd_q[k] ^ cd_q2[k]) & ctrl_q[IRQ_EN_BASE + IRQ_EN_STEP*k];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            bus2_q <= '0;
            div_a  <= '0;
            div_b  <= '0;
            cd_q   <= '0;
            cd_q2  <= '0;
            pend   <= 1'b0;
        end else begin
            cd_q  <= card_det;
            cd_q2 <= cd_q;
            if (|hit)     pend <= 1'b1;
            else if (ack) pend <= 1'b0;
            if (wr_en) begin
                case (idx)
                    IDX_IRQ:   ctrl_q <= wdata[7:1];
                    IDX_BUS2:  bus2_q <= wdata[7:2];
                    IDX_DIV_A: div_a  <= wdata;
                    IDX_DIV_B: div_b  <= wdata;
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        case (idx)
            IDX_IRQ:   rd_val = {ctrl_q, pend};
            IDX_BUS2:  rd_val = {bus2_q, cd_q};
            IDX_DIV_A: rd_val = div_a;
            IDX_DIV_B: rd_val = div_b;
            IDX_REV:   rd_val = REVISION;
            default:   rd_val = '0;
        endcase
    end

    assign ts_en     = bus2_q[5:4];
    assign tuner_rel = {bus2_q[2], bus2_q[3]};
    assign irq_n     = ~pend;
endmodule

// File: rtl/hbm_read_path.sv
module hbm_read_path
    import hbm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_go,
    input  reg_kind_e         kind,
    input  logic [DATA_W-1:0] local_val,
    input  logic              dn_valid,
    input  logic [DATA_W-1:0] dn_data,
    output logic [DATA_W-1:0] rdata,
    output logic              pend
);
    always_ff @(posedge clk) begin
        if (rst) begin
            rdata <= '0;
            pend  <= 1'b0;
        end else if (pend && dn_valid) begin
            rdata <= dn_data;
            pend  <= 1'b0;
        end else if (rd_go) begin
            case (kind)
                RK_LOCAL: rdata <= local_val;
                RK_DOWN:  pend  <= 1'b1;
                default:  rdata <= '0;
            endcase
        end
    end
endmodule

// File: rtl/hbus_mux8_slave.sv
module hbus_mux8_slave
    import hbm_pkg::*;
#(
    parameter logic [7:0] REVISION = 8'h21
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       cs_n,
    input  logic       ads,
    input  logic       wr_n,
    input  logic       rd_n,
    input  logic [7:0] bus_in,
    output logic [7:0] bus_out,
    output logic       bus_oe,
    output logic       rdy_n,
    output logic       irq_n,
    input  logic [1:0] card_det,
    output logic [3:0] dn_idx,
    output logic [7:0] dn_wdata,
    output logic       dn_wr_en,
    output logic       dn_rd_en,
    input  logic       dn_rd_valid,
    input  logic [7:0] dn_rd_data,
    output logic [1:0] ts_en,
    output logic [1:0] tuner_rel,
    output logic [7:0] div_a,
    output logic [7:0] div_b
);
    host_evt_t         evt;
    logic [IDX_W-1:0]  idx;
    reg_kind_e         kind;
    logic              data_wr, data_rd, loc_wr, ack_rd, pend;
    logic [DATA_W-1:0] loc_val;

    hbm_capture u_cap (
        .clk(clk), .rst(rst), .cs_n(cs_n), .ads(ads),
        .wr_n(wr_n), .rd_n(rd_n), .bus_in(bus_in), .evt(evt)
    );

    hbm_index #(.W(IDX_W)) u_idx (
        .clk(clk), .rst(rst), .load(evt.wr_go & evt.ads),
        .din(evt.data[IDX_W-1:0]), .idx(idx)
    );

    assign kind    = classify(idx);
    assign data_wr = evt.wr_go & ~evt.ads;
    assign data_rd = evt.rd_go & ~evt.ads;
    assign loc_wr  = data_wr & (kind == RK_LOCAL);
    assign ack_rd  = data_rd & (idx == IDX_IRQ);

    hbm_local_regs #(.REVISION(REVISION)) u_loc (
        .clk(clk), .rst(rst), .wr_en(loc_wr), .ack(ack_rd), .idx(idx),
        .wdata(evt.data), .card_det(card_det), .rd_val(loc_val),
        .ts_en(ts_en), .tuner_rel(tuner_rel), .div_a(div_a), .div_b(div_b),
        .irq_n(irq_n)
    );

    hbm_read_path u_rp (
        .clk(clk), .rst(rst), .rd_go(data_rd), .kind(kind), .local_val(loc_val),
        .dn_valid(dn_rd_valid), .dn_data(dn_rd_data), .rdata(bus_out), .pend(pend)
    );

    assign dn_idx   = idx;
    assign dn_wdata = evt.data;
    assign dn_wr_en = data_wr & (kind == RK_DOWN);
    assign dn_rd_en = data_rd & (kind == RK_DOWN);
    assign rdy_n    = pend | data_rd;
    assign bus_oe   = evt.rd_hold & ~evt.ads;
endmodule

// File: rtl/hbm_checker.sv
module hbm_checker (
    input logic       clk,
    input logic       rst,
    input logic       cs_n,
    input logic       dn_wr_en,
    input logic       dn_rd_en,
    input logic [3:0] dn_idx,
    input logic       rdy_n,
    input logic       irq_n,
    input logic       ack
);
    // R3: one write strobe per host strobe
    a_r3_wr_single: assert property (@(posedge clk) disable iff (rst)
        dn_wr_en |=> !dn_wr_en);

    // R5: one read strobe per host strobe
    a_r5_rd_single: assert property (@(posedge clk) disable iff (rst)
        dn_rd_en |=> !dn_rd_en);

    // R5: host is held off after a downstream read is issued
    a_r5_rdy_wait: assert property (@(posedge clk) disable iff (rst)
        dn_rd_en |=> rdy_n);

    // R6: downstream strobes only name downstream indexes
    a_r6_dn_range: assert property (@(posedge clk) disable iff (rst)
        (dn_wr_en || dn_rd_en) |-> (dn_idx >= 4'h4 && dn_idx <= 4'hA));

    // R8: interrupt held until acknowledged
    a_r8_irq_hold: assert property (@(posedge clk) disable iff (rst)
        (!irq_n && !ack) |=> !irq_n);

    // R9: deselected host cycles raise no downstream strobe
    a_r9_cs_gate: assert property (@(posedge clk) disable iff (rst)
        $past(cs_n) |-> (!dn_wr_en && !dn_rd_en));
endmodule

bind hbus_mux8_slave hbm_checker u_chk (
    .clk(clk), .rst(rst), .cs_n(cs_n), .dn_wr_en(dn_wr_en), .dn_rd_en(dn_rd_en),
    .dn_idx(dn_idx), .rdy_n(rdy_n), .irq_n(irq_n), .ack(ack_rd)
);

// File: tb/tb_hbus_mux8_slave.sv
module tb_hbus_mux8_slave;
    localparam logic [7:0] REV = 8'h21;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cs_n = 1'b1, ads = 1'b0, wr_n = 1'b1, rd_n = 1'b1;
    logic [7:0] bus_in = '0;
    logic [7:0] bus_out;
    logic       bus_oe, rdy_n, irq_n;
    logic [1:0] card_det = 2'b10;
    logic [3:0] dn_idx;
    logic [7:0] dn_wdata;
    logic       dn_wr_en, dn_rd_en;
    logic       dn_rd_valid = 1'b0;
    logic [7:0] dn_rd_data = '0;
    logic [1:0] ts_en, tuner_rel;
    logic [7:0] div_a, div_b;

    always #10 clk = ~clk;

    hbus_mux8_slave #(.REVISION(REV)) dut (
        .clk(clk), .rst(rst), .cs_n(cs_n), .ads(ads), .wr_n(wr_n), .rd_n(rd_n),
        .bus_in(bus_in), .bus_out(bus_out), .bus_oe(bus_oe), .rdy_n(rdy_n),
        .irq_n(irq_n), .card_det(card_det), .dn_idx(dn_idx), .dn_wdata(dn_wdata),
        .dn_wr_en(dn_wr_en), .dn_rd_en(dn_rd_en), .dn_rd_valid(dn_rd_valid),
        .dn_rd_data(dn_rd_data), .ts_en(ts_en), .tuner_rel(tuner_rel),
        .div_a(div_a), .div_b(div_b)
    );

    int checks = 0, errors = 0;
    logic [7:0] m_bus2 = '0, m_div_a = '0, m_div_b = '0;

    int         w_pulses, r_pulses, r_wait;
    logic [3:0] w_idx, r_idx;
    logic [7:0] w_data, r_val;
    int         resp_delay = 2;
    logic [7:0] resp_data = '0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic check_cfg(input string req);
        chk(ts_en == m_bus2[5:4], req, ts_en, m_bus2[5:4]);
        chk(tuner_rel == {m_bus2[2], m_bus2[3]}, req, tuner_rel, {m_bus2[2], m_bus2[3]});
        chk(div_a == m_div_a, req, div_a, m_div_a);
        chk(div_b == m_div_b, req, div_b, m_div_b);
    endtask

    task automatic bus_wr(input logic a, input logic [7:0] v, input int hold, input logic csn);
        w_pulses = 0;
        @(negedge clk);
        cs_n = csn; ads = a; bus_in = v; wr_n = 1'b0;
        for (int i = 0; i < hold; i++) begin
            @(negedge clk);
            if (dn_wr_en) begin w_pulses++; w_idx = dn_idx; w_data = dn_wdata; end
        end
        wr_n = 1'b1; cs_n = 1'b1;
        @(negedge clk);
        if (dn_wr_en) w_pulses++;
    endtask

    task automatic set_idx(input logic [7:0] v);
        bus_wr(1'b1, v, 1, 1'b0);
    endtask

    task automatic bus_rd();
        int respond_at;
        respond_at = -1; r_pulses = 0; r_wait = 0;
        @(negedge clk);
        cs_n = 1'b0; ads = 1'b0; rd_n = 1'b0;
        for (int i = 1; i < 60; i++) begin
            @(negedge clk);
            dn_rd_valid = 1'b0;
            if (dn_rd_en) begin r_pulses++; r_idx = dn_idx; respond_at = i + resp_delay; end
            if (i >= 2 && !rdy_n && bus_oe) begin r_wait = i; r_val = bus_out; break; end
            if (i == respond_at) begin dn_rd_valid = 1'b1; dn_rd_data = resp_data; end
        end
        rd_n = 1'b1; cs_n = 1'b1; dn_rd_valid = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R10 reset state
        chk(rdy_n == 1'b0, "R10 rdy_n", rdy_n, 0);
        chk(irq_n == 1'b1, "R10 irq_n", irq_n, 1);
        chk(bus_oe == 1'b0, "R10 bus_oe", bus_oe, 0);
        check_cfg("R10 cfg");

        // R2 bus-control register
        set_idx(8'h01);
        bus_wr(1'b0, 8'h3C, 2, 1'b0);
        m_bus2 = 8'h3C;
        check_cfg("R2 bus2 0x3C");
        chk(w_pulses == 0, "R3 no strobe on local write", w_pulses, 0);

        // R11 / R4 card-detect readback
        repeat (3) @(negedge clk);
        bus_rd();
        chk(r_val == 8'h3E, "R11 bus2 read", r_val, 8'h3E);
        chk(r_wait == 2, "R4 local read wait", r_wait, 2);
        bus_wr(1'b0, 8'h03, 2, 1'b0);
        m_bus2 = 8'h00;
        bus_rd();
        chk(r_val == 8'h02, "R11 low bits read-only", r_val, 8'h02);
        bus_wr(1'b0, 8'h34, 2, 1'b0);
        m_bus2 = 8'h34;
        check_cfg("R2 per-channel tuner release");

        // R1 index persistence and upper-bit masking
        set_idx(8'h0C);
        bus_wr(1'b0, 8'h12, 2, 1'b0);
        bus_wr(1'b0, 8'h34, 2, 1'b0);
        m_div_a = 8'h34;
        check_cfg("R1 index persists");
        set_idx(8'hFD);
        bus_wr(1'b0, 8'h56, 2, 1'b0);
        m_div_b = 8'h56;
        check_cfg("R1 upper bits ignored");

        // R3 downstream write with a long strobe
        set_idx(8'h06);
        bus_wr(1'b0, 8'hA5, 4, 1'b0);
        chk(w_pulses == 1, "R3 pulse count", w_pulses, 1);
        chk(w_idx == 4'h6, "R3 dn_idx", w_idx, 6);
        chk(w_data == 8'hA5, "R3 dn_wdata", w_data, 8'hA5);
        check_cfg("R3 cfg untouched");

        // R5 downstream read
        set_idx(8'h07);
        resp_delay = 3; resp_data = 8'h5A;
        bus_rd();
        chk(r_val == 8'h5A, "R5 read data", r_val, 8'h5A);
        chk(r_wait == 5, "R5 wait cycles", r_wait, 5);
        chk(r_pulses == 1, "R5 rd pulse count", r_pulses, 1);
        chk(r_idx == 4'h7, "R5 dn_idx", r_idx, 7);
        resp_delay = 1; resp_data = 8'hC3;
        bus_rd();
        chk(r_val == 8'hC3, "R5 second read data", r_val, 8'hC3);
        chk(r_wait == 3, "R5 short wait", r_wait, 3);

        // R6 unmapped
        set_idx(8'h0B);
        bus_rd();
        chk(r_val == 8'h00, "R6 unmapped read 0xB", r_val, 0);
        chk(r_pulses == 0, "R6 no rd strobe", r_pulses, 0);
        set_idx(8'h0E);
        bus_wr(1'b0, 8'h77, 2, 1'b0);
        chk(w_pulses == 0, "R6 no wr strobe", w_pulses, 0);
        check_cfg("R6 cfg untouched");
        set_idx(8'h02);
        bus_rd();
        chk(r_val == 8'h00, "R6 unmapped read 0x2", r_val, 0);

        // R7 revision
        set_idx(8'h0F);
        bus_rd();
        chk(r_val == REV, "R7 revision", r_val, REV);
        bus_wr(1'b0, 8'h00, 2, 1'b0);
        bus_rd();
        chk(r_val == REV, "R7 read-only", r_val, REV);

        // R8 interrupt
        set_idx(8'h00);
        bus_wr(1'b0, 8'h44, 2, 1'b0);
        bus_rd();
        chk(r_val == 8'h44, "R8 enables readback", r_val, 8'h44);
        @(negedge clk);
        card_det = 2'b11;
        repeat (3) @(negedge clk);
        chk(irq_n == 1'b0, "R8 irq asserts", irq_n, 0);
        repeat (5) @(negedge clk);
        chk(irq_n == 1'b0, "R8 irq holds", irq_n, 0);
        bus_rd();
        chk(r_val == 8'h45, "R8 ack read value", r_val, 8'h45);
        chk(irq_n == 1'b1, "R8 irq cleared", irq_n, 1);
        bus_wr(1'b0, 8'h04, 2, 1'b0);
        @(negedge clk);
        card_det = 2'b01;
        repeat (4) @(negedge clk);
        chk(irq_n == 1'b1, "R8 disabled slot", irq_n, 1);
        card_det = 2'b00;
        repeat (3) @(negedge clk);
        chk(irq_n == 1'b0, "R8 enabled slot 0", irq_n, 0);
        bus_rd();
        chk(irq_n == 1'b1, "R8 second ack", irq_n, 1);

        // R9 chip select gating
        set_idx(8'h06);
        bus_wr(1'b0, 8'h11, 2, 1'b1);
        chk(w_pulses == 0, "R9 deselected data write", w_pulses, 0);
        bus_wr(1'b1, 8'h01, 2, 1'b1);
        bus_wr(1'b0, 8'h99, 2, 1'b0);
        chk(w_pulses == 1 && w_idx == 4'h6, "R9 index kept", w_idx, 6);
        check_cfg("R9 cfg untouched");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule